// File: doc/BRIEF.md
# Addressed Latch Port for Neuron Channel Access

This block sits on a simple synchronous host bus and gives software byte-wide access to a large number of digital channels of a neural device under test. A host address carries three fields: an upper window field that must equal a base value set by configuration switches, a group field that picks one of three latch banks, and a 4-bit index that picks one latch inside the bank. The window, group and index are turned into one-hot enables by three 16-way decoders, one per bank.

Write latches stage outgoing bytes one at a time. Their contents reach the device pins only while a gate bit in its own control latch is set, so a full pattern is prepared quietly and then released in a single cycle. Read latches sample the device outputs every cycle and hold still while the host is reading them. A mode control latch drives eight device mode lines, including the learn/direct selector.

With the default parameters there are 7 write and 7 read latches, for 112 channels, and 2 control latches.

Top module: `chanlatch_port`

## Requirements
- R1: The port responds only when addr[13:6] equals base_sw. With any other window value no enable is raised, no latch changes, and rdata_oe stays 0.
- R2: addr[5:4] selects the group (0 write bank, 1 read bank, 2 control bank, 3 none) and addr[3:0] the latch index. At most one latch enable is active in any cycle.
- R3: With wr_stb high and a matching address in group 0 and index k below NUM_WR, write latch k takes wdata at that clock edge. All other write latches keep their values.
- R4: Control latch 1 bit 0 is the output gate. While it is 0, dev_out is all zeros. While it is 1, dev_out[8k+7:8k] equals write latch k for every k, all in the same cycle.
- R5: With rd_en high and a matching address in group 1 and index k below NUM_RD, rdata_oe is 1 and rdata equals read latch k. Otherwise rdata_oe is 0 and rdata is 0.
- R6: Read latch k loads dev_in[8k+7:8k] on every clock edge, except that it holds its value while the host reads it.
- R7: Control latch 0 drives mode_o (bit 0 feedback, 1 force high, 2 force low, 3 data select, 4 assign, 5 storage enable, 6 program pulse, 7 learn when 1, direct when 0). Writing it leaves dev_out unchanged.
- R8: A write in group 3, or to an index with no latch behind it (write index 7 or above, control index 2 or above), changes no latch.
- R9: After reset, all latches are zero, the gate is closed, dev_out and mode_o are zero, and rdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and latch clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_sw | input | BASE_W | Switch-set window base |
| addr | input | ADDR_W | Host address: window, group, index |
| wdata | input | 8 | Host write data |
| wr_stb | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read request |
| rdata | output | 8 | Read data (zero when not driving) |
| rdata_oe | output | 1 | Bus drive enable for rdata |
| dev_in | input | NUM_RD*8 | Device outputs sampled by read latches |
| dev_out | output | NUM_WR*8 | Gated write latch contents to the device |
| mode_o | output | 8 | Device mode lines from control latch 0 |

## Verification
The bench builds the block with its defaults: an 8-bit window, 7 write latches, 7 read latches and 2 control latches behind 16-way decoders. This leaves indices 7 to 15 of the data banks and 2 to 15 of the control bank decoded but unpopulated, so random addresses regularly hit holes that must stay inert. Random writes toggle the gate bit among ordinary staging writes, which exercises release and re-closing in many orders. Directed cases change the switch base during the run and change dev_in during a read.

// File: rtl/chanlatch_pkg.sv
package chanlatch_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    GRP_WR   = 2'd0,
    GRP_RD   = 2'd1,
    GRP_CTL  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam int CTL_MODE_IDX = 0;
  localparam int CTL_GATE_IDX = 1;
  localparam int GATE_BIT     = 0;
endpackage

// File: rtl/chanlatch_decode.sv
module chanlatch_decode
  import chanlatch_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int IDX_W  = 4,
  localparam int ADDR_W = BASE_W + 2 + IDX_W,
  localparam int DEC_N  = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base_sw,
  output logic              hit,
  output logic [DEC_N-1:0]  en_wr,
  output logic [DEC_N-1:0]  en_rd,
  output logic [DEC_N-1:0]  en_ctl
);
  grp_e             grp;
  logic [IDX_W-1:0] idx;

  assign hit = (addr[ADDR_W-1 -: BASE_W] == base_sw);
  assign grp = grp_e'(addr[IDX_W +: 2]);
  assign idx = addr[IDX_W-1:0];

  for (genvar k = 0; k < DEC_N; k++) begin : g_dec
    localparam logic [IDX_W-1:0] KV = IDX_W'(k);
    assign en_wr[k]  = hit && (grp == GRP_WR)  && (idx == KV);
    assign en_rd[k]  = hit && (grp == GRP_RD)  && (idx == KV);
    assign en_ctl[k] = hit && (grp == GRP_CTL) && (idx == KV);
  end
endmodule

// File: rtl/chanlatch_bank.sv
module chanlatch_bank
  import chanlatch_pkg::*;
#(
  parameter int NUM = 7,
  localparam int BITS = NUM * BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NUM-1:0]  load_en,
  input  logic [BITS-1:0] d_in,
  output logic [BITS-1:0] q
);
  logic [BITS-1:0] q_nxt;

  for (genvar k = 0; k < NUM; k++) begin : g_lat
    always_comb begin
      q_nxt[k*BYTE_W +: BYTE_W] = q[k*BYTE_W +: BYTE_W];
      if (load_en[k]) begin
        q_nxt[k*BYTE_W +: BYTE_W] = d_in[k*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/chanlatch_rdsel.sv
module chanlatch_rdsel
  import chanlatch_pkg::*;
#(
  parameter int NUM   = 7,
  parameter int DEC_N = 16
) (
  input  logic                  rd_en,
  input  logic [DEC_N-1:0]      en_rd,
  input  logic [NUM*BYTE_W-1:0] q,
  output logic [BYTE_W-1:0]     rdata,
  output logic                  rdata_oe,
  output logic [NUM-1:0]        frozen
);
  always_comb begin
    rdata    = '0;
    rdata_oe = 1'b0;
    frozen   = '0;
    for (int k = 0; k < NUM; k++) begin
      if (rd_en && en_rd[k]) begin
        rdata     = rdata | q[k*BYTE_W +: BYTE_W];
        rdata_oe  = 1'b1;
        frozen[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chanlatch_port.sv
module chanlatch_port
  import chanlatch_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int IDX_W   = 4,
  parameter int NUM_WR  = 7,
  parameter int NUM_RD  = 7,
  parameter int NUM_CTL = 2,
  localparam int ADDR_W = BASE_W + 2 + IDX_W,
  localparam int DEC_N  = 1 << IDX_W,
  localparam int WR_BITS  = NUM_WR * BYTE_W,
  localparam int RD_BITS  = NUM_RD * BYTE_W,
  localparam int CTL_BITS = NUM_CTL * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BASE_W-1:0]   base_sw,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                wr_stb,
  input  logic                rd_en,
  output logic [BYTE_W-1:0]   rdata,
  output logic                rdata_oe,
  input  logic [RD_BITS-1:0]  dev_in,
  output logic [WR_BITS-1:0]  dev_out,
  output logic [BYTE_W-1:0]   mode_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // address window and one-hot enables
  logic             hit;
  logic [DEC_N-1:0] en_wr;
  logic [DEC_N-1:0] en_rd;
  logic [DEC_N-1:0] en_ctl;

  chanlatch_decode #(.BASE_W(BASE_W), .IDX_W(IDX_W)) dec_i (
    .addr    (addr),
    .base_sw (base_sw),
    .hit     (hit),
    .en_wr   (en_wr),
    .en_rd   (en_rd),
    .en_ctl  (en_ctl)
  );

  // write (staging) bank
  logic [NUM_WR-1:0]  wr_load;
  logic [WR_BITS-1:0] wr_q;
  assign wr_load = {NUM_WR{wr_stb}} & en_wr[NUM_WR-1:0];

  chanlatch_bank #(.NUM(NUM_WR)) wr_bank_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (wr_load),
    .d_in    ({NUM_WR{wdata}}),
    .q       (wr_q)
  );

  // control bank
  logic [NUM_CTL-1:0]  ctl_load;
  logic [CTL_BITS-1:0] ctl_q;
  assign ctl_load = {NUM_CTL{wr_stb}} & en_ctl[NUM_CTL-1:0];

  chanlatch_bank #(.NUM(NUM_CTL)) ctl_bank_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (ctl_load),
    .d_in    ({NUM_CTL{wdata}}),
    .q       (ctl_q)
  );

  // read (capture) bank, frozen while addressed by an active read
  logic [NUM_RD-1:0]  rd_frozen;
  logic [RD_BITS-1:0] rd_q;

  chanlatch_bank #(.NUM(NUM_RD)) rd_bank_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (~rd_frozen),
    .d_in    (dev_in),
    .q       (rd_q)
  );

  chanlatch_rdsel #(.NUM(NUM_RD), .DEC_N(DEC_N)) rdsel_i (
    .rd_en    (rd_en),
    .en_rd    (en_rd),
    .q        (rd_q),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .frozen   (rd_frozen)
  );

  // output release and mode lines
  logic gate;
  assign gate    = ctl_q[CTL_GATE_IDX*BYTE_W + GATE_BIT];
  assign dev_out = gate ? wr_q : '0;
  assign mode_o  = ctl_q[CTL_MODE_IDX*BYTE_W +: BYTE_W];
endmodule

// File: rtl/chanlatch_port_chk.sv
module chanlatch_port_chk #(
  parameter int DEC_N    = 16,
  parameter int ADDR_W   = 14,
  parameter int WR_BITS  = 56,
  parameter int CTL_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hit,
  input logic [ADDR_W-1:0]   addr,
  input logic                rd_en,
  input logic [DEC_N-1:0]    en_wr,
  input logic [DEC_N-1:0]    en_rd,
  input logic [DEC_N-1:0]    en_ctl,
  input logic [WR_BITS-1:0]  staged,
  input logic [CTL_BITS-1:0] ctl_q,
  input logic                gate,
  input logic [WR_BITS-1:0]  dev_out,
  input logic [7:0]          rdata,
  input logic                rdata_oe
);
  assert_nohit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (en_wr == '0) && (en_rd == '0) && (en_ctl == '0));

  assert_enable_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_wr, en_rd, en_ctl}));

  assert_gate_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> (dev_out == '0));

  assert_drive_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (rd_en && hit));

  assert_idle_bus_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && $past(rdata_oe) && $stable(addr)) |-> $stable(rdata));

  assert_miss_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(staged) && $stable(ctl_q)));
endmodule

bind chanlatch_port chanlatch_port_chk #(
  .DEC_N(DEC_N), .ADDR_W(ADDR_W), .WR_BITS(WR_BITS), .CTL_BITS(CTL_BITS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .hit      (hit),
  .addr     (addr),
  .rd_en    (rd_en),
  .en_wr    (en_wr),
  .en_rd    (en_rd),
  .en_ctl   (en_ctl),
  .staged   (wr_q),
  .ctl_q    (ctl_q),
  .gate     (gate),
  .dev_out  (dev_out),
  .rdata    (rdata),
  .rdata_oe (rdata_oe)
);

// File: tb/chanlatch_port_tb_top.sv
module chanlatch_port_tb_top;
  localparam int NWR = 7;
  localparam int NRD = 7;
  localparam int NCT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  base_sw = 8'hA5;
  logic [13:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_stb = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [NRD*8-1:0] dev_in = '0;
  logic [NWR*8-1:0] dev_out;
  logic [7:0]  mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] wr_m  [NWR];
  logic [7:0] ctl_m [NCT];

  always #2 clk = ~clk;

  chanlatch_port dut_i (
    .clk(clk), .rst_n(rst_n), .base_sw(base_sw), .addr(addr), .wdata(wdata),
    .wr_stb(wr_stb), .rd_en(rd_en), .rdata(rdata), .rdata_oe(rdata_oe),
    .dev_in(dev_in), .dev_out(dev_out), .mode_o(mode_o)
  );

  function automatic logic [NWR*8-1:0] exp_dev_out();
    logic [NWR*8-1:0] v = '0;
    if (ctl_m[1][0]) begin
      for (int k = 0; k < NWR; k++) v[k*8 +: 8] = wr_m[k];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] b, input logic [1:0] g, input logic [3:0] i,
                        input logic [7:0] d, input string tag);
    @(negedge clk);
    addr = {b, g, i}; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (b == base_sw) begin
      if (g == 2'd0 && i < NWR) wr_m[i] = d;
      if (g == 2'd2 && i < NCT) ctl_m[i] = d;
    end
    #1;
    chk({tag, " dev_out"}, 64'(dev_out), 64'(exp_dev_out()));
    chk({tag, " mode_o"}, 64'(mode_o), 64'(ctl_m[0]));
  endtask

  // new dev_in is captured at the next edge, then read
  task automatic bus_rd(input logic [7:0] b, input logic [1:0] g, input logic [3:0] i,
                        input logic [NRD*8-1:0] pins, input string tag);
    logic hitrd;
    @(negedge clk);
    dev_in = pins;
    @(negedge clk);
    addr = {b, 2'(g), i}; rd_en = 1'b1;
    #1;
    hitrd = (b == base_sw) && (g == 2'd1) && (i < NRD);
    chk({tag, " rdata_oe"}, 64'(rdata_oe), 64'(hitrd));
    chk({tag, " rdata"}, 64'(rdata), hitrd ? 64'(pins[i*8 +: 8]) : 64'd0);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NRD*8-1:0] v, w;
    logic [7:0] bb, dd;
    logic [1:0] gg;
    logic [3:0] ii;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NWR; k++) wr_m[k] = '0;
    for (int k = 0; k < NCT; k++) ctl_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 dev_out", 64'(dev_out), 64'd0);
    chk("R9 mode_o", 64'(mode_o), 64'd0);
    chk("R9 rdata_oe", 64'(rdata_oe), 64'd0);

    // R3/R4 staging hidden while gate closed, then released together
    for (int k = 0; k < NWR; k++) bus_wr(base_sw, 2'd0, 4'(k), 8'(8'h11 * (k + 1)), "R3 R4 stage");
    chk("R4 closed", 64'(dev_out), 64'd0);
    bus_wr(base_sw, 2'd2, 4'd1, 8'h01, "R4 release");
    chk("R4 all bytes", 64'(dev_out), 64'h77665544332211);

    // R7 learn bit leaves data path alone
    bus_wr(base_sw, 2'd2, 4'd0, 8'h80, "R7 learn");
    chk("R7 learn dev_out", 64'(dev_out), 64'h77665544332211);
    chk("R7 learn mode", 64'(mode_o), 64'h80);

    // R1 wrong window ignored, then base switched
    bus_wr(base_sw ^ 8'h40, 2'd0, 4'd2, 8'hEE, "R1 miss");
    chk("R1 miss", 64'(dev_out[23:16]), 64'h33);
    base_sw = 8'h3C;
    bus_wr(8'hA5, 2'd0, 4'd0, 8'hDE, "R1 old base");
    bus_wr(8'h3C, 2'd0, 4'd0, 8'hBE, "R1 new base");
    chk("R1 new base byte", 64'(dev_out[7:0]), 64'hBE);

    // R8 holes and group 3
    bus_wr(base_sw, 2'd3, 4'd1, 8'h55, "R8 group3");
    bus_wr(base_sw, 2'd0, 4'd9, 8'h55, "R8 wr hole");
    bus_wr(base_sw, 2'd2, 4'd5, 8'h00, "R8 ctl hole");
    chk("R8 gate kept", 64'(dev_out), 64'(exp_dev_out()));

    // R5 reads, misses and holes
    v = 56'h0F1E2D3C4B5A69;
    bus_rd(base_sw, 2'd1, 4'd4, v, "R5 hit");
    bus_rd(base_sw, 2'd1, 4'd12, v, "R5 hole");
    bus_rd(base_sw ^ 8'h01, 2'd1, 4'd4, v, "R5 miss");
    bus_rd(base_sw, 2'd0, 4'd4, v, "R5 wrong grp");

    // R6 hold during read
    w = 56'hA1B2C3D4E5F607;
    @(negedge clk);
    addr = {base_sw, 2'd1, 4'd3}; rd_en = 1'b1; dev_in = w;
    #1 chk("R6 first", 64'(rdata), 64'(v[31:24]));
    @(negedge clk); #1 chk("R6 held", 64'(rdata), 64'(v[31:24]));
    @(negedge clk); rd_en = 1'b0;
    bus_rd(base_sw, 2'd1, 4'd3, w, "R6 reloaded");

    // random mix
    for (int n = 0; n < 400; n++) begin
      bb = ($urandom % 4 != 0) ? base_sw : 8'($urandom);
      gg = 2'($urandom);
      ii = ($urandom % 2 != 0) ? 4'($urandom % 8) : 4'($urandom);
      dd = 8'($urandom);
      if (gg == 2'd1) begin
        v = {24'($urandom), 32'($urandom)};
        bus_rd(bb, gg, ii, v, "R5 R6 random read");
      end else begin
        bus_wr(bb, gg, ii, dd, "R2 R3 R8 random write");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule